// File: doc/BRIEF.md
# Abort Fault Status Recorder

This block sits beside a processor's memory system and turns the fault indications raised during one access into the status and address words that exception handlers read. Each cycle it looks at a vector of fault requests, picks the one with the highest rank, and forms a status word from it. The word holds a scattered 5-bit cause code, a domain number with a validity flag, and a bit that tells the two kinds of bus error apart. When the abort strobe is high, it decides which vector the core must take: prefetch for instruction-side aborts, data for data-side and cache-maintenance aborts. In the same edge it writes the status and address registers that belong to that kind of abort.

The registers are the instruction status, instruction address, data status, data address and watchpoint address registers. Each keeps its value until an abort that targets it arrives. A combinational read port returns any one of them. A cache-maintenance-by-address operation that hits a translation problem is handled in a special way. It is reported as a data abort, and the data status register shows a dedicated maintenance code. The underlying reason goes to the instruction status register instead.

Top module: `abort_status_unit`

## Requirements
- R1: After reset all five registers read as zero and the `pabt`, `dabt` and `imprecise` outputs are low.
- R2: The rank of `fault_req` bits runs from index 0 (highest) to 10 (lowest): 0 alignment, 1 TLB miss, 2 external abort on translation, 3 translation, 4 access flag, 5 domain, 6 permission, 7 precise external, 8 imprecise external, 9 parity, 10 debug event. Only the highest asserted bit is recorded.
- R3: Each status word has this layout: code bit 4 in bit 10, code bits 3:0 in bits 3:0, the domain-valid flag in bit 8, the domain number in bits 7:4, the external type in bit 12, and all other bits zero. The 5-bit codes are:
  - alignment 00001, TLB miss 00000, parity 11000, debug 00010
  - precise external 01000, imprecise external 10110
  - for the level-dependent kinds, the value shown first applies when `page_lvl`=0 (section or first level) and the value shown second when `page_lvl`=1: translation external 01100/01110, translation 00101/00111, access flag 00011/00110, domain 01001/01011, permission 01101/01111.
- R4: The domain-valid flag is 1, and bits 7:4 hold `domain`, only for these faults: page-level translation external, page translation, access flag, domain, permission, precise external and debug. For all other faults both the flag and bits 7:4 are zero.
- R5: Bit 12 equals `ext_slverr` only for the two translation-external kinds and the precise and imprecise external kinds. It is zero for every other fault.
- R6: A strobed instruction-side fault other than debug pulses `pabt` for one cycle. It writes the status word to the instruction status register and `fault_addr` to the instruction address register. The data-side registers are left as they were.
- R7: A strobed instruction-side debug event pulses `pabt` and writes only the instruction status register.
- R8: A strobed data-side fault pulses `dabt` and writes the status word to the data status register and `fault_addr` to the data address register. A data-side debug event also writes `instr_addr` to the watchpoint register. `pabt` and `dabt` are never high together.
- R9: On a data-side abort with `icm_op` high where the selected fault ranks below TLB miss, a data abort is taken. The data status register gets code 00100 with every other field zero, and the instruction status register gets the selected fault's word. The instruction address register gets `instr_addr`, and the data address register gets `fault_addr`.
- R10: Code 00100 never appears in the instruction status register. When `icm_op` is high and the selected fault is alignment or TLB miss, the abort is recorded as an ordinary data abort.
- R11: No register changes and no vector pulses when the strobe is low, or when the strobe is high with no `fault_req` bit set, even if `icm_op` is high.
- R12: `imprecise` pulses together with the vector pulse exactly when the recorded fault is the imprecise external abort.
- R13: `rd_sel` 0..4 returns the instruction status, instruction address, data status, data address and watchpoint registers in that order. Other values return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| abort_stb | input | 1 | Record the current fault request |
| side_instr | input | 1 | 1 = instruction-side access, 0 = data-side |
| icm_op | input | 1 | Access is an instruction cache maintenance by address |
| fault_req | input | 11 | Fault request bits, index 0 highest rank |
| page_lvl | input | 1 | 1 = page / second-level variant |
| ext_slverr | input | 1 | External error type for bit 12 |
| domain | input | 4 | Domain number of the access |
| fault_addr | input | AW | Faulting address |
| instr_addr | input | AW | Address of the instruction causing the abort |
| rd_sel | input | 3 | Register read select |
| rd_data | output | 32 | Selected register contents |
| pabt | output | 1 | Prefetch abort vector pulse |
| dabt | output | 1 | Data abort vector pulse |
| imprecise | output | 1 | Recorded abort was imprecise |

## Verification
Some properties are checked on every cycle. The two vector pulses are mutually exclusive and stay quiet whenever the strobe was low. The maintenance code never reaches the instruction status register. The external-type bit in the data status register only accompanies an external code. The watchpoint register only moves on a data abort, and the imprecise flag only rises with a vector. The bench's directed scenarios show the rest: the priority choice among simultaneous faults, the exact code for each level variant, domain masking, the split of writes between registers for each abort type, the maintenance-operation redirect, and that earlier register contents survive untouched.

// File: rtl/abort_status_unit.sv
module abort_status_unit #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          abort_stb,
  input  logic          side_instr,
  input  logic          icm_op,
  input  logic [10:0]   fault_req,
  input  logic          page_lvl,
  input  logic          ext_slverr,
  input  logic [3:0]    domain,
  input  logic [AW-1:0] fault_addr,
  input  logic [AW-1:0] instr_addr,
  input  logic [2:0]    rd_sel,
  output logic [31:0]   rd_data,
  output logic          pabt,
  output logic          dabt,
  output logic          imprecise
);

  localparam logic [3:0] SEL_IMPR = 4'd8;
  localparam logic [3:0] SEL_DBG  = 4'd10;
  localparam logic [31:0] ICM_WORD = 32'h0000_0004;

  logic          hit;
  logic [3:0]    sel;
  logic [4:0]    code;
  logic          dv, ext;
  logic [31:0]   fsr_word;
  logic          icm_case, wr;

  logic [31:0]   ifsr_q, dfsr_q;
  logic [AW-1:0] ifar_q, far_q, wfar_q;
  logic          pabt_q, dabt_q, impr_q;

  always_comb begin
    hit = 1'b0;
    sel = '0;
    for (int i = 10; i >= 0; i--) begin
      if (fault_req[i]) begin
        hit = 1'b1;
        sel = 4'(i);
      end
    end
  end

  always_comb begin
    dv  = 1'b0;
    ext = 1'b0;
    unique case (sel)
      4'd0:    code = 5'b00001;
      4'd1:    code = 5'b00000;
      4'd2:    begin code = page_lvl ? 5'b01110 : 5'b01100; dv = page_lvl; ext = ext_slverr; end
      4'd3:    begin code = page_lvl ? 5'b00111 : 5'b00101; dv = page_lvl; end
      4'd4:    begin code = page_lvl ? 5'b00110 : 5'b00011; dv = 1'b1; end
      4'd5:    begin code = page_lvl ? 5'b01011 : 5'b01001; dv = 1'b1; end
      4'd6:    begin code = page_lvl ? 5'b01111 : 5'b01101; dv = 1'b1; end
      4'd7:    begin code = 5'b01000; dv = 1'b1; ext = ext_slverr; end
      4'd8:    begin code = 5'b10110; ext = ext_slverr; end
      4'd9:    code = 5'b11000;
      default: begin code = 5'b00010; dv = 1'b1; end
    endcase
  end

  assign fsr_word = {19'd0, ext, 1'b0, code[4], 1'b0, dv, (dv ? domain : 4'd0), code[3:0]};
  assign wr       = abort_stb && hit;
  assign icm_case = !side_instr && icm_op && (sel >= 4'd2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ifsr_q <= '0;
      dfsr_q <= '0;
      ifar_q <= '0;
      far_q  <= '0;
      wfar_q <= '0;
      pabt_q <= 1'b0;
      dabt_q <= 1'b0;
      impr_q <= 1'b0;
    end else begin
      pabt_q <= 1'b0;
      dabt_q <= 1'b0;
      impr_q <= 1'b0;
      if (wr) begin
        impr_q <= (sel == SEL_IMPR);
        if (side_instr) begin
          pabt_q <= 1'b1;
          ifsr_q <= fsr_word;
          if (sel != SEL_DBG) ifar_q <= fault_addr;
        end else begin
          dabt_q <= 1'b1;
          far_q  <= fault_addr;
          if (icm_case) begin
            dfsr_q <= ICM_WORD;
            ifsr_q <= fsr_word;
            ifar_q <= instr_addr;
          end else begin
            dfsr_q <= fsr_word;
            if (sel == SEL_DBG) wfar_q <= instr_addr;
          end
        end
      end
    end
  end

  always_comb begin
    unique case (rd_sel)
      3'd0:    rd_data = ifsr_q;
      3'd1:    rd_data = 32'(ifar_q);
      3'd2:    rd_data = dfsr_q;
      3'd3:    rd_data = 32'(far_q);
      3'd4:    rd_data = 32'(wfar_q);
      default: rd_data = '0;
    endcase
  end

  assign pabt      = pabt_q;
  assign dabt      = dabt_q;
  assign imprecise = impr_q;

  p_vec_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(pabt_q && dabt_q));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !abort_stb |=> (!pabt_q && !dabt_q));

  p_ifsr_no_icm_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(ifsr_q[10] == 1'b0 && ifsr_q[3:0] == 4'b0100));

  p_ext_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dfsr_q[12] |-> ({dfsr_q[10], dfsr_q[3:0]} inside {5'b01100, 5'b01110, 5'b01000, 5'b10110}));

  p_wfar_on_dabt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wfar_q) |-> dabt_q);

  p_impr_with_vec_r12: assert property (@(posedge clk) disable iff (!rst_n)
    impr_q |-> (pabt_q || dabt_q));

endmodule

// File: tb/tb_abort_status_unit.sv
module tb_abort_status_unit;
  logic        clk = 0, rst_n = 0, abort_stb = 0, side_instr = 0, icm_op = 0;
  logic [10:0] fault_req = '0;
  logic        page_lvl = 0, ext_slverr = 0;
  logic [3:0]  domain = '0;
  logic [31:0] fault_addr = '0, instr_addr = '0;
  logic [2:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic        pabt, dabt, imprecise;
  int checks = 0, failures = 0;
  bit done = 0;

  abort_status_unit #(.AW(32)) dut (.*);

  always #10 clk = ~clk;

  function automatic logic [31:0] fw(input logic [4:0] c, input logic v,
                                     input logic [3:0] d, input logic e);
    return {19'd0, e, 1'b0, c[4], 1'b0, v, d, c[3:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [2:0] s, output logic [31:0] d);
    rd_sel = s;
    #1;
    d = rd_data;
  endtask

  task automatic regs(input string req, input logic [31:0] e0, e1, e2, e3, e4);
    logic [31:0] d;
    rd(0, d); chk({req, " ifsr"}, d, e0);
    rd(1, d); chk({req, " ifar"}, d, e1);
    rd(2, d); chk({req, " dfsr"}, d, e2);
    rd(3, d); chk({req, " far"},  d, e3);
    rd(4, d); chk({req, " wfar"}, d, e4);
  endtask

  task automatic fire(input logic stb, input logic si, input logic [10:0] req,
                      input logic pg, input logic ex, input logic [3:0] dm,
                      input logic icm, input logic [31:0] fa, input logic [31:0] ia);
    @(negedge clk);
    abort_stb = stb; side_instr = si; fault_req = req; page_lvl = pg;
    ext_slverr = ex; domain = dm; icm_op = icm; fault_addr = fa; instr_addr = ia;
    @(negedge clk);
    abort_stb = 0; fault_req = '0; icm_op = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    regs("R1", 0, 0, 0, 0, 0);
    chk("R1 pulses", {29'd0, pabt, dabt, imprecise}, 0);
    for (int s = 5; s < 8; s++) begin
      rd(3'(s), d); chk("R13 unused select", d, 0);
    end
  endtask

  task automatic t_priority_instr;
    fire(1, 1, 11'b000_1110_0000, 0, 0, 4'd5, 0, 32'h1000_0040, 32'h2000_0000);
    chk("R6 pabt", {30'd0, pabt, dabt}, 2'b10);
    regs("R2/R6", fw(5'b01001, 1, 5, 0), 32'h1000_0040, 0, 0, 0);
  endtask

  task automatic t_codes_data;
    fire(1, 0, 11'b000_0000_1000, 0, 0, 4'd7, 0, 32'h3000_0100, 32'h0);
    chk("R8 dabt", {30'd0, pabt, dabt}, 2'b01);
    regs("R3/R4 section xlat", fw(5'b01001, 1, 5, 0), 32'h1000_0040,
         fw(5'b00101, 0, 0, 0), 32'h3000_0100, 0);
    fire(1, 0, 11'b000_0000_1000, 1, 0, 4'd7, 0, 32'h3000_0200, 32'h0);
    regs("R3/R4 page xlat", fw(5'b01001, 1, 5, 0), 32'h1000_0040,
         fw(5'b00111, 1, 7, 0), 32'h3000_0200, 0);
    fire(1, 0, 11'b010_0000_0000, 0, 1, 4'd3, 0, 32'h3000_0300, 32'h0);
    regs("R3 parity", fw(5'b01001, 1, 5, 0), 32'h1000_0040,
         fw(5'b11000, 0, 0, 0), 32'h3000_0300, 0);
    fire(1, 0, 11'b000_0000_0110, 0, 0, 4'd3, 0, 32'h3000_0400, 32'h0);
    regs("R2/R3 tlb miss", fw(5'b01001, 1, 5, 0), 32'h1000_0040,
         0, 32'h3000_0400, 0);
    fire(1, 0, 11'b000_0000_0100, 0, 1, 4'd3, 0, 32'h3000_0500, 32'h0);
    regs("R4/R5 first-level xlat ext", fw(5'b01001, 1, 5, 0), 32'h1000_0040,
         fw(5'b01100, 0, 0, 1), 32'h3000_0500, 0);
  endtask

  task automatic t_ext;
    fire(1, 0, 11'b001_0000_0000, 0, 1, 4'd9, 0, 32'h4000_0000, 32'h0);
    chk("R12 imprecise", {29'd0, pabt, dabt, imprecise}, 3'b011);
    regs("R5 imprecise slverr", fw(5'b01001, 1, 5, 0), 32'h1000_0040,
         fw(5'b10110, 0, 0, 1), 32'h4000_0000, 0);
    fire(1, 0, 11'b001_1000_0000, 0, 0, 4'd9, 0, 32'h4000_0010, 32'h0);
    chk("R12 precise", {31'd0, imprecise}, 0);
    regs("R2/R5 precise", fw(5'b01001, 1, 5, 0), 32'h1000_0040,
         fw(5'b01000, 1, 9, 0), 32'h4000_0010, 0);
    fire(1, 0, 11'b000_0001_0000, 1, 1, 4'd2, 0, 32'h4000_0020, 32'h0);
    regs("R5 access no ext", fw(5'b01001, 1, 5, 0), 32'h1000_0040,
         fw(5'b00110, 1, 2, 0), 32'h4000_0020, 0);
  endtask

  task automatic t_debug;
    fire(1, 1, 11'b100_0000_0000, 0, 0, 4'd4, 0, 32'h5000_0000, 32'h5000_0004);
    chk("R7 pabt", {30'd0, pabt, dabt}, 2'b10);
    regs("R7 ifsr only", fw(5'b00010, 1, 4, 0), 32'h1000_0040,
         fw(5'b00110, 1, 2, 0), 32'h4000_0020, 0);
    fire(1, 0, 11'b100_0000_0000, 0, 0, 4'd6, 0, 32'h6000_0000, 32'h6000_0008);
    regs("R8 data debug", fw(5'b00010, 1, 4, 0), 32'h1000_0040,
         fw(5'b00010, 1, 6, 0), 32'h6000_0000, 32'h6000_0008);
  endtask

  task automatic t_icm;
    fire(1, 0, 11'b000_0000_1000, 1, 0, 4'd1, 1, 32'h7000_0000, 32'h7100_0000);
    chk("R9 dabt", {30'd0, pabt, dabt}, 2'b01);
    regs("R9 icm redirect", fw(5'b00111, 1, 1, 0), 32'h7100_0000,
         fw(5'b00100, 0, 0, 0), 32'h7000_0000, 32'h6000_0008);
    fire(1, 0, 11'b000_0000_0001, 0, 0, 4'd1, 1, 32'h7200_0000, 32'h7300_0000);
    regs("R10 icm with alignment", fw(5'b00111, 1, 1, 0), 32'h7100_0000,
         fw(5'b00001, 0, 0, 0), 32'h7200_0000, 32'h6000_0008);
  endtask

  task automatic t_nowrite;
    fire(1, 0, 11'b000_0000_0000, 0, 0, 4'd1, 1, 32'hDEAD_0000, 32'hBEEF_0000);
    chk("R11 no fault pulses", {30'd0, pabt, dabt}, 0);
    fire(0, 1, 11'b000_0000_0001, 0, 0, 4'd1, 0, 32'hDEAD_0000, 32'hBEEF_0000);
    chk("R11 no strobe pulses", {30'd0, pabt, dabt}, 0);
    fire(0, 0, 11'b100_0000_0000, 0, 0, 4'd1, 0, 32'hDEAD_0000, 32'hBEEF_0000);
    regs("R11 hold", fw(5'b00111, 1, 1, 0), 32'h7100_0000,
         fw(5'b00001, 0, 0, 0), 32'h7200_0000, 32'h6000_0008);
    @(negedge clk);
    chk("R6 pulse one cycle", {30'd0, pabt, dabt}, 0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_priority_instr();
    t_codes_data();
    t_ext();
    t_debug();
    t_icm();
    t_nowrite();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule